// File: doc/BRIEF.md
# Power-of-Two Clock Post-Divider with Glitch-Free Gating

This block takes a fast divider clock and produces a slower complementary clock pair from it. A 2-bit select picks a half-period of 1, 2, 4 or 8 input cycles. Because each output level is held for an equal number of input cycles, the output always has a 50% duty cycle. With the smallest ratio, the output toggles on every input edge. The input clock is therefore expected to run at twice the fastest output rate.

An active-high enable first passes through a short synchronizer. It is then honoured only at output-period boundaries. Dropping the enable lets the current high phase finish, and the pair then parks with the true output low and the complement high. Raising the enable starts a complete new period, whose first high phase has full length. A change of the ratio select is also taken only at the start of a period. As a result, no enable or ratio change can produce a shortened pulse.

Top module: `postdiv_gated`

## Requirements
- R1: Select code 2'b00 gives a half-period of 1 input cycle, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8, while the enable is high.
- R2: Every complete high phase and every complete low phase of the output has the same length, so the duty cycle is 50%.
- R3: The complement output is always the inverse of the true output, including during reset.
- R4: When the enable falls during a high phase, that high phase still lasts its full half-period before the output goes low.
- R5: While the enable is low, once the output has gone low it stays low and the complement stays high, for as long as the enable remains low.
- R6: After the enable rises on a parked output, the output rises within SYNC_STAGES+2 input cycles, and its first high phase is a full half-period.
- R7: A new select value is adopted only at a rising edge of the output. The high and low phases already started with the old ratio keep the old length.
- R8: While reset is asserted, and after its release until a rising edge is permitted, the true output is low and the complement is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divider clock, twice the fastest output rate |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | Ratio select code |
| oe | input | 1 | Output enable, active high, may be asynchronous |
| clk_out | output | 1 | True divided clock |
| clk_out_n | output | 1 | Complement divided clock |

## Verification
The embedded assertions are evaluated on every cycle. They check that the complement is always the inverse of the true output, that a rise happens only after a synchronized enable, and that a fall happens only once the phase counter has expired. They also check that the latched ratio changes only together with a rising edge, and that a parked output stays parked while the enable is low. Other properties depend on whole sequences and are measured by the bench's directed scenarios: the exact phase lengths for each code, equal high and low times, a high phase finishing after a disable, the latency from enable to first edge, and the old ratio persisting to the end of its period.

// File: rtl/postdiv_pkg.sv
package postdiv_pkg;

    localparam int MAX_SHIFT = 3;
    localparam int CNT_W     = MAX_SHIFT;

    typedef enum logic [1:0] {
        DIV_1 = 2'b00,
        DIV_2 = 2'b01,
        DIV_4 = 2'b10,
        DIV_8 = 2'b11
    } div_code_e;

    typedef struct packed {
        logic            level;
        logic [CNT_W-1:0] cnt;
        div_code_e       code;
    } phase_t;

    // last count value of a half-period: half length minus one
    function automatic logic [CNT_W-1:0] half_last(input div_code_e c);
        logic [CNT_W:0] one_hot;
        one_hot = (CNT_W+1)'(1) << c;
        return CNT_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/postdiv_oe_sync.sv
module postdiv_oe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/postdiv_phase.sv
module postdiv_phase
    import postdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] code_in,
    input  logic       enable,
    output logic       level
);
    phase_t st, st_nx;

    always_comb begin
        st_nx = st;
        if (st.cnt != '0) begin
            st_nx.cnt = st.cnt - 1'b1;
        end else if (st.level) begin
            st_nx.level = 1'b0;
            st_nx.cnt   = half_last(st.code);
        end else if (enable) begin
            st_nx.level = 1'b1;
            st_nx.code  = div_code_e'(code_in);
            st_nx.cnt   = half_last(div_code_e'(code_in));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.level <= 1'b0;
            st.cnt   <= '0;
            st.code  <= DIV_1;
        end else begin
            st <= st_nx;
        end
    end

    assign level = st.level;

    // R6
    rise_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st.level) |-> $past(enable));

    // R4
    fall_at_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st.level) |-> $past(st.cnt) == '0);

    // R7
    code_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(st.code) |-> $rose(st.level));

    // R5
    parked_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (!st.level && st.cnt == '0 && !enable) |=> !st.level);
endmodule

// File: rtl/postdiv_out_stage.sv
module postdiv_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic p,
    output logic n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            p <= 1'b0;
            n <= 1'b1;
        end else begin
            p <= level;
            n <= ~level;
        end
    end

    // R3
    complement_chk: assert property (@(posedge clk) disable iff (rst)
        n == ~p);

    // R8
    reset_park_chk: assert property (@(posedge clk)
        $past(rst) |-> (!p && n));
endmodule

// File: rtl/postdiv_gated.sv
module postdiv_gated
    import postdiv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] div_sel,
    input  logic       oe,
    output logic       clk_out,
    output logic       clk_out_n
);
    logic oe_s;
    logic level;

    postdiv_oe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (oe),
        .q   (oe_s)
    );

    postdiv_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .code_in (div_sel),
        .enable  (oe_s),
        .level   (level)
    );

    postdiv_out_stage u_out (
        .clk (clk),
        .rst (rst),
        .level (level),
        .p   (clk_out),
        .n   (clk_out_n)
    );
endmodule

// File: tb/postdiv_gated_test.sv
module postdiv_gated_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] div_sel = 2'b00;
    logic       oe = 1'b0;
    logic       clk_out, clk_out_n;

    int errors = 0;
    int checks = 0;
    int compl_bad = 0;
    logic cur = 1'b0;

    always #5 clk = ~clk;

    postdiv_gated #(.SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .div_sel(div_sel), .oe(oe),
        .clk_out(clk_out), .clk_out_n(clk_out_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cur = clk_out;
        if (clk_out_n !== ~clk_out) compl_bad++;
    endtask

    task automatic wait_level(input logic v);
        for (int i = 0; i < 100 && cur !== v; i++) tick();
    endtask

    task automatic measure(input logic v, output int len);
        len = 1;
        tick();
        while (cur === v && len < 100) begin
            len++;
            tick();
        end
    endtask

    // R8: parked during and after reset
    task automatic t_reset();
        int bad = 0;
        rst = 1'b1; oe = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick();
            if (clk_out !== 1'b0 || clk_out_n !== 1'b1) bad++;
        end
        rst = 1'b0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (clk_out !== 1'b0 || clk_out_n !== 1'b1) bad++;
        end
        chk(bad == 0, "R8 reset park", bad, 0);
    endtask

    // R1 R2 R3: steady division for each code
    task automatic t_ratio(input logic [1:0] code);
        int h = 1 << code;
        int len;
        int bad = 0;
        div_sel = code; oe = 1'b1;
        for (int i = 0; i < 40; i++) tick();
        wait_level(1'b0);
        wait_level(1'b1);
        compl_bad = 0;
        for (int i = 0; i < 3; i++) begin
            measure(1'b1, len); if (len != h) bad++;
            measure(1'b0, len); if (len != h) bad++;
        end
        chk(bad == 0, "R1 R2 phase lengths", bad, 0);
        chk(compl_bad == 0, "R3 complement", compl_bad, 0);
    endtask

    // R4 R5: disable during high, then during low
    task automatic t_disable();
        int len;
        int bad = 0;
        div_sel = 2'b10; oe = 1'b1;
        for (int i = 0; i < 30; i++) tick();
        wait_level(1'b0);
        wait_level(1'b1);
        oe = 1'b0;
        measure(1'b1, len);
        chk(len == 4, "R4 high completes", len, 4);
        for (int i = 0; i < 40; i++) begin
            tick();
            if (cur !== 1'b0 || clk_out_n !== 1'b1) bad++;
        end
        chk(bad == 0, "R5 parked after high", bad, 0);
        oe = 1'b1;
        for (int i = 0; i < 30; i++) tick();
        wait_level(1'b1);
        wait_level(1'b0);
        oe = 1'b0;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (cur !== 1'b0) bad++;
        end
        chk(bad == 0, "R5 parked after low", bad, 0);
    endtask

    // R6: enable latency and full first phase
    task automatic t_enable();
        int n = 0;
        int len;
        div_sel = 2'b01;
        oe = 1'b1;
        while (n < 20) begin
            tick(); n++;
            if (cur === 1'b1) break;
        end
        chk(n <= 4, "R6 enable latency", n, 4);
        measure(1'b1, len);
        chk(len == 2, "R6 first high full", len, 2);
        measure(1'b0, len);
        chk(len == 2, "R6 following low", len, 2);
    endtask

    // R7: ratio change mid-high keeps the old ratio to the period end
    task automatic t_change();
        int len;
        div_sel = 2'b11; oe = 1'b1;
        for (int i = 0; i < 40; i++) tick();
        wait_level(1'b0);
        wait_level(1'b1);
        div_sel = 2'b00;
        measure(1'b1, len); chk(len == 8, "R7 old high kept", len, 8);
        measure(1'b0, len); chk(len == 8, "R7 old low kept", len, 8);
        measure(1'b1, len); chk(len == 1, "R7 new high", len, 1);
        measure(1'b0, len); chk(len == 1, "R7 new low", len, 1);
        for (int i = 0; i < 7; i++) tick();
        wait_level(1'b1);
        div_sel = 2'b11;
        measure(1'b1, len); chk(len == 1, "R7 short high kept", len, 1);
        measure(1'b0, len); chk(len == 1, "R7 short low kept", len, 1);
        measure(1'b1, len); chk(len == 8, "R7 long high adopted", len, 8);
    endtask

    initial begin
        t_reset();
        t_ratio(2'b00);
        t_ratio(2'b01);
        t_ratio(2'b10);
        t_ratio(2'b11);
        t_disable();
        t_enable();
        t_change();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule